// File: doc/BRIEF.md
# Periodic Thermal Sensor Scanner

This block keeps the readings of up to eight on-chip temperature sensors fresh. The sensors do not refresh on their own, so a programmable countdown timer starts a sampling round at a fixed interval. In each round the block visits every sensor that software has switched on, one at a time, from the lowest index up. It takes the sensor out of reset, raises its enable, waits for its done strobe and stores the returned code in that sensor's own result register. A sensor that is not being converted is kept in reset with its enable low, which saves power and wear.

Software uses a plain register port. Writes take effect on the clock edge and reads are combinational. The port sets the sensor enable mask, the round period and an over-temperature threshold, and reads back the results and the status flags. A code above the threshold raises a sticky alert. A conversion that never finishes is cut off after a fixed number of cycles and raises a sticky error. No interface carries a data stream, so there is no valid/ready pair and no back-pressure. The sensor handshake is a plain enable/done pair, and each result stays in its register until it is overwritten.

Top module: `thermal_poll_ctrl`

## Requirements
- R1: After reset every sensor is held in reset (`sens_rst_n` all 0, `sens_en` all 0), `alert` and `err` are 0, and all readable registers return 0.
- R2: With a non-zero period P in register 1, a sampling round starts every P cycles, with the first one in the cycle after the write. With a period of 0 no round starts. A round start that falls while a round is still running is dropped.
- R3: Within a round, enabled sensors are converted one at a time in ascending index order. At most one bit of `sens_en` is ever high.
- R4: A sensor has `sens_rst_n` high only while it is being converted, and `sens_en` is never high for a sensor that is held in reset.
- R5: When the active sensor pulses its done bit, its data is captured. Register 8+i then reads the code in bits [9:0] and a valid flag of 1 in bit 10.
- R6: A sensor whose bit in the enable mask (register 0, bit i) is 0 is skipped and its valid flag is cleared. Clearing the bit during that sensor's conversion drops its enable and reset release in the cycle after the write, and it does not count as a timeout.
- R7: A conversion still without done after 256 cycles of enable is aborted. The sensor's valid flag is cleared and the sticky `err` output (status register 3, bit 1) is set. Writing 1 to bit 1 of register 3 clears it.
- R8: A captured code strictly greater than the threshold (register 2, bits [9:0]) sets the sticky `alert` output (register 3, bit 0). A code equal to the threshold does not set it. Writing 1 to bit 0 of register 3 clears it, and writing 0 leaves it set.
- R9: Registers 0, 1 and 2 read back the last written mask, period and threshold. Register 3 reads {err, alert}. Addresses 4 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| sens_done | input | NUM_SENS | Per-sensor conversion-complete pulse |
| sens_data | input | NUM_SENS*CODE_W | Per-sensor conversion codes, sensor i at bits [i*CODE_W +: CODE_W] |
| sens_en | output | NUM_SENS | Per-sensor conversion enable |
| sens_rst_n | output | NUM_SENS | Per-sensor active-low reset; low holds the sensor in reset |
| alert | output | 1 | Sticky over-temperature flag |
| err | output | 1 | Sticky conversion-timeout flag |

## Verification
The bench builds the block with its default parameters: eight sensors, 10-bit codes, a 16-bit period and a 256-cycle timeout. With these values a full scan over all eight indices, a timeout that runs to its full length and the readback of every result address all fit within the cycle budget. A behavioural sensor model answers each enable after a fixed latency. The model can also be told never to answer, which makes the timeout and the disable-during-conversion paths reachable on demand.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_CONV = 2'd2
  } seq_state_t;

  localparam int ADDR_MASK   = 0;
  localparam int ADDR_PERIOD = 1;
  localparam int ADDR_THRESH = 2;
  localparam int ADDR_STATUS = 3;
  localparam int RES_BASE    = 8;
  localparam int ST_ALERT_BIT = 0;
  localparam int ST_ERR_BIT   = 1;
endpackage

// File: rtl/tpc_timer.sv
module tpc_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);
  logic [PERIOD_W-1:0] cnt;

  assign tick = (period != '0) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (period == '0) begin
      cnt <= '0;
    end else if (cnt == '0) begin
      cnt <= period - PERIOD_W'(1);
    end else begin
      cnt <= cnt - PERIOD_W'(1);
    end
  end
endmodule

// File: rtl/tpc_seq.sv
module tpc_seq
  import tpc_pkg::*;
#(
  parameter int N       = 8,
  parameter int TIMEOUT = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [N-1:0]         en_mask,
  input  logic [N-1:0]         done,
  output logic [N-1:0]         sens_en,
  output logic [N-1:0]         sens_rst_n,
  output logic                 cap_stb,
  output logic                 tmo_stb,
  output logic [((N>1)?$clog2(N):1)-1:0] idx,
  output logic                 busy
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int TMO_W = $clog2(TIMEOUT + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N - 1);

  seq_state_t       state;
  logic [TMO_W-1:0] tmo;
  logic             cur_en;
  logic             cur_done;
  logic             expired;
  logic             active;

  assign cur_en   = en_mask[idx];
  assign cur_done = done[idx];
  assign active   = (state == ST_CONV) && cur_en;
  assign expired  = (tmo == TMO_LAST);
  assign busy     = (state != ST_IDLE);
  assign cap_stb  = active && cur_done;
  assign tmo_stb  = active && !cur_done && expired;

  always_comb begin
    sens_en    = '0;
    sens_rst_n = '0;
    if (active) begin
      sens_en[idx]    = 1'b1;
      sens_rst_n[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      tmo   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (tick) begin
            idx   <= '0;
            state <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (cur_en) begin
            tmo   <= '0;
            state <= ST_CONV;
          end else if (idx == IDX_LAST) begin
            state <= ST_IDLE;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        ST_CONV: begin
          if (!cur_en || cur_done || expired) begin
            if (idx == IDX_LAST) begin
              state <= ST_IDLE;
            end else begin
              idx   <= idx + IDX_W'(1);
              state <= ST_SCAN;
            end
          end else begin
            tmo <= tmo + TMO_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tpc_results.sv
module tpc_results #(
  parameter int N      = 8,
  parameter int CODE_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap_stb,
  input  logic                 tmo_stb,
  input  logic [((N>1)?$clog2(N):1)-1:0] idx,
  input  logic [N*CODE_W-1:0]  sens_data,
  input  logic [N-1:0]         en_mask,
  input  logic [CODE_W-1:0]    thresh,
  input  logic                 clr_alert,
  input  logic                 clr_err,
  output logic [N*CODE_W-1:0]  codes,
  output logic [N-1:0]         valid,
  output logic                 alert,
  output logic                 err
);
  logic [CODE_W-1:0] data_sel;

  assign data_sel = sens_data[idx*CODE_W +: CODE_W];

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        codes[i*CODE_W +: CODE_W] <= '0;
        valid[i]                  <= 1'b0;
      end else if (!en_mask[i]) begin
        valid[i] <= 1'b0;
      end else if (cap_stb && (int'(idx) == i)) begin
        codes[i*CODE_W +: CODE_W] <= data_sel;
        valid[i]                  <= 1'b1;
      end else if (tmo_stb && (int'(idx) == i)) begin
        valid[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alert <= 1'b0;
      err   <= 1'b0;
    end else begin
      if (cap_stb && (data_sel > thresh)) alert <= 1'b1;
      else if (clr_alert)                 alert <= 1'b0;
      if (tmo_stb)      err <= 1'b1;
      else if (clr_err) err <= 1'b0;
    end
  end
endmodule

// File: rtl/tpc_regs.sv
module tpc_regs
  import tpc_pkg::*;
#(
  parameter int N        = 8,
  parameter int CODE_W   = 10,
  parameter int PERIOD_W = 16,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [N*CODE_W-1:0] codes,
  input  logic [N-1:0]        valid,
  input  logic                alert,
  input  logic                err,
  output logic [N-1:0]        en_mask,
  output logic [PERIOD_W-1:0] period,
  output logic [CODE_W-1:0]   thresh,
  output logic                clr_alert,
  output logic                clr_err,
  output logic [DATA_W-1:0]   rdata
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic             wr_status;
  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  ridx;
  logic             in_res;

  assign wr_status = we && (addr == ADDR_W'(ADDR_STATUS));
  assign clr_alert = wr_status && wdata[ST_ALERT_BIT];
  assign clr_err   = wr_status && wdata[ST_ERR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_mask <= '0;
      period  <= '0;
      thresh  <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(ADDR_MASK))   en_mask <= wdata[N-1:0];
      if (addr == ADDR_W'(ADDR_PERIOD)) period  <= wdata[PERIOD_W-1:0];
      if (addr == ADDR_W'(ADDR_THRESH)) thresh  <= wdata[CODE_W-1:0];
    end
  end

  assign off    = addr - ADDR_W'(RES_BASE);
  assign ridx   = off[IDX_W-1:0];
  assign in_res = (int'(addr) >= RES_BASE) && (int'(off) < N);

  always_comb begin
    rdata = '0;
    if (in_res) begin
      rdata = DATA_W'({valid[ridx], codes[ridx*CODE_W +: CODE_W]});
    end else begin
      case (int'(addr))
        ADDR_MASK:   rdata = DATA_W'(en_mask);
        ADDR_PERIOD: rdata = DATA_W'(period);
        ADDR_THRESH: rdata = DATA_W'(thresh);
        ADDR_STATUS: rdata = DATA_W'({err, alert});
        default:     rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/thermal_poll_ctrl.sv
module thermal_poll_ctrl #(
  parameter int NUM_SENS = 8,
  parameter int CODE_W   = 10,
  parameter int PERIOD_W = 16,
  parameter int TIMEOUT  = 256,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  input  logic [NUM_SENS-1:0]        sens_done,
  input  logic [NUM_SENS*CODE_W-1:0] sens_data,
  output logic [NUM_SENS-1:0]        sens_en,
  output logic [NUM_SENS-1:0]        sens_rst_n,
  output logic                       alert,
  output logic                       err
);
  localparam int IDX_W = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1;

  logic [NUM_SENS-1:0]        en_mask;
  logic [PERIOD_W-1:0]        period_q;
  logic [CODE_W-1:0]          thresh_q;
  logic                       clr_alert;
  logic                       clr_err;
  logic                       tick;
  logic                       cap_stb;
  logic                       tmo_stb;
  logic [IDX_W-1:0]           cur_idx;
  logic                       seq_busy;
  logic [NUM_SENS*CODE_W-1:0] codes;
  logic [NUM_SENS-1:0]        valid;

  tpc_regs #(
    .N(NUM_SENS), .CODE_W(CODE_W), .PERIOD_W(PERIOD_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .codes(codes), .valid(valid), .alert(alert),
    .err(err), .en_mask(en_mask), .period(period_q), .thresh(thresh_q),
    .clr_alert(clr_alert), .clr_err(clr_err), .rdata(reg_rdata)
  );

  tpc_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .period(period_q), .tick(tick)
  );

  tpc_seq #(.N(NUM_SENS), .TIMEOUT(TIMEOUT)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en_mask(en_mask),
    .done(sens_done), .sens_en(sens_en), .sens_rst_n(sens_rst_n),
    .cap_stb(cap_stb), .tmo_stb(tmo_stb), .idx(cur_idx), .busy(seq_busy)
  );

  tpc_results #(.N(NUM_SENS), .CODE_W(CODE_W)) u_res (
    .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .tmo_stb(tmo_stb),
    .idx(cur_idx), .sens_data(sens_data), .en_mask(en_mask),
    .thresh(thresh_q), .clr_alert(clr_alert), .clr_err(clr_err),
    .codes(codes), .valid(valid), .alert(alert), .err(err)
  );
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
  parameter int N        = 8,
  parameter int PERIOD_W = 16,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N-1:0]        sens_en,
  input logic [N-1:0]        sens_rst_n,
  input logic [N-1:0]        en_mask,
  input logic [PERIOD_W-1:0] period_q,
  input logic                busy,
  input logic                alert,
  input logic                err,
  input logic                reg_we,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_wdata
);
  logic wr_st;
  assign wr_st = reg_we && (reg_addr == ADDR_W'(tpc_pkg::ADDR_STATUS));

  AST_SINGLE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sens_en)); // R3
  AST_EN_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (sens_en & ~sens_rst_n) == '0); // R4
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sens_en & ~en_mask) == '0); // R6
  AST_ZERO_PERIOD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q == '0 && !busy) |=> !busy); // R2
  AST_ALERT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alert && !(wr_st && reg_wdata[0])) |=> alert); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(wr_st && reg_wdata[1])) |=> err); // R7
endmodule

bind thermal_poll_ctrl tpc_checker #(
  .N(NUM_SENS), .PERIOD_W(PERIOD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sens_en(sens_en), .sens_rst_n(sens_rst_n),
  .en_mask(en_mask), .period_q(period_q), .busy(seq_busy), .alert(alert),
  .err(err), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/tb_thermal_poll_ctrl.sv
`timescale 1ns/1ps
module tb_thermal_poll_ctrl;
  localparam int N = 8;
  localparam int CW = 10;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int LAT = 3;

  typedef struct packed {
    logic [7:0]    mask;
    logic [CW-1:0] thr;
    logic [CW-1:0] seed;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{mask: 8'hFF, thr: 10'd1023, seed: 10'd5},
    '{mask: 8'hA5, thr: 10'd300,  seed: 10'd100},
    '{mask: 8'h01, thr: 10'd50,   seed: 10'd50},
    '{mask: 8'h80, thr: 10'd0,    seed: 10'd900}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic reg_we = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [N-1:0] sens_done = '0;
  logic [N*CW-1:0] sens_data;
  logic [N-1:0] sens_en, sens_rst_n;
  logic alert, err;

  logic [CW-1:0] cv [N];
  logic [N-1:0] dead = '0;
  int mcnt [N];
  int checks = 0, errors = 0;
  bit finished = 0;

  logic [N-1:0] prev_en = '0;
  int log_idx [64];
  int log_n = 0;
  int hi_cnt [N];
  int rise0 [8];
  int rise0_n = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  for (genvar i = 0; i < N; i++) begin : g_data
    assign sens_data[i*CW +: CW] = cv[i];
  end

  thermal_poll_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sens_done(sens_done),
    .sens_data(sens_data), .sens_en(sens_en), .sens_rst_n(sens_rst_n),
    .alert(alert), .err(err)
  );

  // sensor model: done pulse LAT cycles after enable rises, unless dead
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (sens_en[i] && sens_rst_n[i]) begin
        mcnt[i] <= mcnt[i] + 1;
        sens_done[i] <= !dead[i] && (mcnt[i] == LAT - 1);
      end else begin
        mcnt[i] <= 0;
        sens_done[i] <= 1'b0;
      end
    end
  end

  // monitor of enable activity
  always @(posedge clk) begin
    cyc = cyc + 1;
    for (int i = 0; i < N; i++) begin
      if (sens_en[i] && !prev_en[i]) begin
        if (log_n < 64) log_idx[log_n] = i;
        log_n = log_n + 1;
        if (i == 0 && rise0_n < 8) begin
          rise0[rise0_n] = cyc;
          rise0_n = rise0_n + 1;
        end
      end
      if (sens_en[i]) hi_cnt[i] = hi_cnt[i] + 1;
    end
    prev_en = sens_en;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1; reg_addr = AW'(a); reg_wdata = DW'(d);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = AW'(a);
    #0.5;
    d = int'(reg_rdata);
  endtask

  task automatic clear_mon();
    log_n = 0; rise0_n = 0;
    for (int i = 0; i < N; i++) hi_cnt[i] = 0;
  endtask

  task automatic run_round(input int wait_cyc);
    clear_mon();
    wr(1, wait_cyc + 100);
    repeat (wait_cyc) @(negedge clk);
    wr(1, 0);
    repeat (10) @(negedge clk);
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_sim();
  end

  initial begin
    int d, k, expa, code;
    for (int i = 0; i < N; i++) begin cv[i] = '0; mcnt[i] = 0; hi_cnt[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(sens_rst_n == '0 && sens_en == '0, "R1 sensors held", int'(sens_rst_n), 0);
    chk(!alert && !err, "R1 flags", int'({err, alert}), 0);
    for (int a = 0; a < 16; a++) begin
      rd(a, d);
      chk(d == 0, "R1 reg zero", d, 0);
    end

    // R9 readback
    wr(0, 16'h5A); wr(2, 16'h1FF); wr(1, 0);
    rd(0, d); chk(d == 16'h5A, "R9 mask", d, 16'h5A);
    rd(2, d); chk(d == 16'h1FF, "R9 thresh", d, 16'h1FF);
    rd(6, d); chk(d == 0, "R9 unused", d, 0);

    // table walk: R3 order, R5 capture, R6 skip, R8 threshold
    for (int v = 0; v < 4; v++) begin
      wr(3, 3);
      wr(0, int'(VECS[v].mask));
      wr(2, int'(VECS[v].thr));
      expa = 0;
      for (int i = 0; i < N; i++) begin
        cv[i] = CW'(int'(VECS[v].seed) + 37 * i);
        if (VECS[v].mask[i] && cv[i] > VECS[v].thr) expa = 1;
      end
      run_round(120);
      k = 0;
      for (int i = 0; i < N; i++) begin
        rd(8 + i, d);
        if (VECS[v].mask[i]) begin
          code = int'(cv[i]) | 1024;
          chk(d == code, "R5 result", d, code);
          chk(k < log_n && log_idx[k] == i, "R3 order", (k < log_n) ? log_idx[k] : -1, i);
          k++;
        end else begin
          chk(d[10] == 1'b0, "R6 skipped invalid", d, 0);
        end
      end
      chk(log_n == k, "R3 visits", log_n, k);
      chk(int'(alert) == expa, "R8 alert", int'(alert), expa);
      chk(sens_rst_n == '0 && sens_en == '0, "R4 idle reset", int'(sens_rst_n), 0);
    end

    // R8 write 0 keeps, write 1 clears
    chk(alert == 1'b1, "R8 precond", int'(alert), 1);
    wr(3, 0); chk(alert == 1'b1, "R8 w0 keeps", int'(alert), 1);
    wr(3, 1); chk(alert == 1'b0, "R8 w1c", int'(alert), 0);

    // R2 period spacing and period zero
    wr(0, 1); clear_mon();
    wr(1, 40);
    repeat (130) @(negedge clk);
    chk(rise0_n >= 3, "R2 rounds", rise0_n, 3);
    chk(rise0[1] - rise0[0] == 40, "R2 spacing", rise0[1] - rise0[0], 40);
    wr(1, 0);
    repeat (10) @(negedge clk);
    k = log_n;
    repeat (200) @(negedge clk);
    chk(log_n == k, "R2 period zero", log_n, k);

    // R7 timeout
    wr(0, 8);
    run_round(30);
    rd(11, d); chk(d[10] == 1'b1, "R7 valid before", int'(d[10]), 1);
    dead[3] = 1'b1;
    wr(3, 3);
    run_round(280);
    chk(hi_cnt[3] == 256, "R7 timeout length", hi_cnt[3], 256);
    chk(err == 1'b1, "R7 err set", int'(err), 1);
    rd(11, d); chk(d[10] == 1'b0, "R7 valid cleared", int'(d[10]), 0);
    rd(3, d); chk(d == 2, "R7 status bit", d, 2);
    wr(3, 2); chk(err == 1'b0, "R7 w1c", int'(err), 0);
    dead[3] = 1'b0;

    // R6 disable during conversion
    dead[1] = 1'b1;
    wr(0, 3); clear_mon();
    wr(1, 600);
    k = 0;
    while (!sens_en[1] && k < 100) begin @(negedge clk); k++; end
    chk(sens_en[1] == 1'b1, "R6 sensor1 active", int'(sens_en[1]), 1);
    repeat (10) @(negedge clk);
    wr(0, 1);
    chk(sens_en[1] == 1'b0 && sens_rst_n[1] == 1'b0, "R6 abort drops", int'({sens_en[1], sens_rst_n[1]}), 0);
    wr(1, 0);
    repeat (20) @(negedge clk);
    chk(err == 1'b0, "R6 not timeout", int'(err), 0);
    rd(9, d); chk(d[10] == 1'b0, "R6 valid cleared", int'(d[10]), 0);
    chk(hi_cnt[1] < 256, "R6 short", hi_cnt[1], 20);
    dead[1] = 1'b0;

    finish_sim();
  end
endmodule